// File: doc/BRIEF.md
# SD Command Response Capture Register

This block watches the command-response line of an SD host. It turns each response that arrives into a parallel frame and keeps only the payload bits of that frame in a 128-bit bank. A short response is 48 bits long and a long response is 136 bits long. The start bit, the transmission bit, the command index and the CRC and end bits are dropped. Software can therefore fetch a status word in a single 32-bit read.

A two-bit kind input chooses where the payload goes:

- **Ordinary short response:** the payload goes to the low word.
- **Automatically issued stop command:** the payload goes to the top word, so the status of the preceding ordinary command stays readable in the low word.
- **Long (card identity or card specific data) response:** the payload fills almost the whole bank.

The bank is read-only from the bus side. It is exposed as four 32-bit words through a combinational read port. A one-cycle strobe marks each completed store, and a separate one-cycle flag reports a frame whose end bit was wrong.

Top module: `sdrsp_capture`

## Requirements
- R1: After a synchronous reset, all four words read as zero and `done_o` and `frame_err_o` are low.
- R2: Byte offset 0 reads bank bits [31:0], offset 4 reads [63:32], offset 8 reads [95:64] and offset 12 reads [127:96].
- R3: Reads at an address that is not a multiple of four, or at an address of 16 or above, return zero.
- R4: Framing:
  - While idle, a 0 sampled on a rising edge is taken as the start bit.
  - The frame is shifted in MSB first.
  - `rsp_kind_i` is latched with the start bit and ignored for the rest of the frame.
  - Kind 2 selects a 136-bit frame; kinds 0, 1 and 3 select a 48-bit frame.
- R5: Kind 0 (and reserved kind 3) copies frame bits [39:8] into bank bits [31:0] and leaves bits [127:32] unchanged.
- R6: Kind 1 (auto stop) copies frame bits [39:8] into bank bits [127:96] and leaves bits [95:0] unchanged.
- R7: Kind 2 copies frame bits [127:8] into bank bits [119:0] and clears bits [127:120].
- R8: Timing of the store:
  - `done_o` is high for exactly one cycle.
  - It rises on the first rising edge after the edge that samples the end bit.
  - The new bank contents are readable from that same edge.
- R9: If the end bit (frame bit 0) is 0:
  - The bank is not changed.
  - `frame_err_o` pulses for one cycle at the time `done_o` would have, and `done_o` stays low.
- R10: A start bit that arrives in the cycle directly after an end bit begins a new frame, and both frames are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rsp_line_i | input | 1 | Serial response line, idles high |
| rsp_kind_i | input | 2 | Placement kind: 0 short, 1 auto stop, 2 long, 3 treated as short |
| rd_addr_i | input | ADDR_W | Byte address of the word to read |
| rd_data_o | output | 32 | Word selected by `rd_addr_i`, zero when out of range |
| done_o | output | 1 | One-cycle strobe: a response was stored |
| frame_err_o | output | 1 | One-cycle strobe: end bit was 0, nothing stored |

## Verification
The bench goes after several placement corners:

- **Stop after ordinary, and ordinary after stop.** Wrong placement or a full-bank write would clobber the word that must survive.
- **Long response.** It must clear the top byte; a design that only ORs in the payload would leave stale stop status there.
- **Kind input changing mid-frame.** An unlatched kind would pick the wrong length or slot.
- **Bad end bit.** A design that ignored the end bit would update the bank and pulse `done_o`.
- **Back-to-back frames.** A design that needs an idle cycle would lose the second start bit.

The arrival cycle of every strobe is also checked against the cycle of the end bit, so an extra or missing pipeline register shows up.

// File: rtl/sdrsp_pkg.sv
package sdrsp_pkg;

    localparam int WORD_W      = 32;
    localparam int NUM_WORDS   = 4;
    localparam int BANK_W      = WORD_W * NUM_WORDS;
    localparam int SHORT_LEN   = 48;
    localparam int LONG_LEN    = 136;
    localparam int CNT_W       = $clog2(LONG_LEN + 1);
    localparam int PAY_LO      = 8;
    localparam int SHORT_PAY_HI = 39;
    localparam int LONG_PAY_HI = 127;
    localparam int LONG_PAY_W  = LONG_PAY_HI - PAY_LO + 1;
    localparam int SHORT_PAY_W = SHORT_PAY_HI - PAY_LO + 1;
    localparam int SR_W        = LONG_PAY_HI + 1;
    localparam int BYTE_SEL_W  = $clog2(WORD_W / 8);
    localparam int WORD_SEL_W  = $clog2(NUM_WORDS);

    typedef enum logic [1:0] {
        KIND_SHORT = 2'd0,
        KIND_STOP  = 2'd1,
        KIND_LONG  = 2'd2,
        KIND_RSVD  = 2'd3
    } rsp_kind_e;

    typedef struct packed {
        rsp_kind_e               kind;
        logic                    end_ok;
        logic [LONG_PAY_W-1:0]   payload;
    } frame_t;

    function automatic logic [CNT_W-1:0] frame_len(rsp_kind_e k);
        return (k == KIND_LONG) ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
    endfunction

endpackage

// File: rtl/sdrsp_deser.sv
module sdrsp_deser
    import sdrsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line_i,
    input  rsp_kind_e kind_i,
    output logic      vld_o,
    output frame_t    frame_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    rsp_kind_e        kind_q;
    logic [SR_W-1:0]  sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            kind_q <= KIND_SHORT;
            sr_q   <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            if (!busy_q) begin
                if (!line_i) begin
                    busy_q <= 1'b1;
                    cnt_q  <= CNT_ONE;
                    kind_q <= kind_i;
                    sr_q   <= '0;
                end
            end else begin
                sr_q  <= {sr_q[SR_W-2:0], line_i};
                cnt_q <= cnt_q + CNT_ONE;
                if (cnt_q == frame_len(kind_q) - CNT_ONE) begin
                    busy_q <= 1'b0;
                    vld_o  <= 1'b1;
                end
            end
        end
    end

    assign frame_o.kind    = kind_q;
    assign frame_o.end_ok  = sr_q[0];
    assign frame_o.payload = sr_q[LONG_PAY_HI:PAY_LO];

    p_vld_single_r8: assert property (@(posedge clk) disable iff (rst)
        vld_o |=> !vld_o);

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q < frame_len(kind_q)));

    p_kind_held_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(kind_q));

endmodule

// File: rtl/sdrsp_bank.sv
module sdrsp_bank
    import sdrsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  frame_t            frame_i,
    output logic [BANK_W-1:0] bank_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int TOP_LO = WORD_W * (NUM_WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_o <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            if (vld_i) begin
                if (!frame_i.end_ok) begin
                    err_o <= 1'b1;
                end else begin
                    done_o <= 1'b1;
                    case (frame_i.kind)
                        KIND_LONG: bank_o <= BANK_W'(frame_i.payload);
                        KIND_STOP: bank_o[BANK_W-1:TOP_LO] <= frame_i.payload[SHORT_PAY_W-1:0];
                        default:   bank_o[WORD_W-1:0]      <= frame_i.payload[SHORT_PAY_W-1:0];
                    endcase
                end
            end
        end
    end

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

    p_bad_end_r9: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !frame_i.end_ok) |=> (err_o && $stable(bank_o)));

    p_short_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (vld_i && frame_i.end_ok && (frame_i.kind == KIND_SHORT || frame_i.kind == KIND_RSVD))
        |=> $stable(bank_o[BANK_W-1:WORD_W]));

    p_stop_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (vld_i && frame_i.end_ok && frame_i.kind == KIND_STOP)
        |=> $stable(bank_o[TOP_LO-1:0]));

    p_long_top_r7: assert property (@(posedge clk) disable iff (rst)
        (vld_i && frame_i.end_ok && frame_i.kind == KIND_LONG)
        |=> (bank_o[BANK_W-1:LONG_PAY_W] == '0));

    p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> (!done_o && !err_o && $stable(bank_o)));

endmodule

// File: rtl/sdrsp_capture.sv
module sdrsp_capture
    import sdrsp_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rsp_line_i,
    input  logic [1:0]        rsp_kind_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              done_o,
    output logic              frame_err_o
);

    localparam int SEL_HI = BYTE_SEL_W + WORD_SEL_W;

    logic              vld;
    frame_t            frame;
    logic [BANK_W-1:0] bank;
    logic [WORD_SEL_W-1:0] word_idx;
    logic              addr_ok;

    sdrsp_deser u_deser (
        .clk    (clk),
        .rst    (rst),
        .line_i (rsp_line_i),
        .kind_i (rsp_kind_e'(rsp_kind_i)),
        .vld_o  (vld),
        .frame_o(frame)
    );

    sdrsp_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (vld),
        .frame_i(frame),
        .bank_o (bank),
        .done_o (done_o),
        .err_o  (frame_err_o)
    );

    assign word_idx = rd_addr_i[SEL_HI-1:BYTE_SEL_W];
    assign addr_ok  = (rd_addr_i[BYTE_SEL_W-1:0] == '0) &&
                      (rd_addr_i[ADDR_W-1:SEL_HI] == '0);

    always_comb begin
        rd_data_o = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (addr_ok && word_idx == WORD_SEL_W'(w)) begin
                rd_data_o = bank[w*WORD_W +: WORD_W];
            end
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!done_o && !frame_err_o));

endmodule

// File: tb/test_sdrsp_capture.sv
`timescale 1ns/1ps
module test_sdrsp_capture;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line = 1'b1;
    logic [1:0]  kind = 2'd0;
    logic [5:0]  rd_addr = 6'd0;
    logic [31:0] rd_data;
    logic        done;
    logic        ferr;

    int checks = 0;
    int fails  = 0;
    int ncyc   = 0;

    logic [128:0]   expq[$];
    string          reqq[$];
    int             stampq[$];
    logic [127:0]   model = '0;
    bit             reset_checked = 0;
    bit             done_prev = 0;

    always #5 clk = ~clk;

    sdrsp_capture i_sdrsp_capture (
        .clk        (clk),
        .rst        (rst),
        .rsp_line_i (line),
        .rsp_kind_i (kind),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .done_o     (done),
        .frame_err_o(ferr)
    );

    always @(posedge clk) ncyc++;

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(int a, output logic [31:0] d);
        rd_addr = 6'(a);
        #0.5;
        d = rd_data;
    endtask

    function automatic logic [135:0] short_f(logic [31:0] p, logic endb);
        return {88'd0, 2'b00, 6'h0d, p, 7'h55, endb};
    endfunction

    function automatic logic [135:0] long_f(logic [119:0] p, logic endb);
        return {2'b00, 6'h3f, p, 7'h2a, endb};
    endfunction

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            line = 1'b1;
        end
    endtask

    // driver: predicts the bank, queues the expectation, then shifts the frame out
    task automatic send(logic [1:0] k, logic [135:0] f, string req);
        int len;
        logic bad;
        len = (k == 2'd2) ? 136 : 48;
        bad = ~f[0];
        if (!bad) begin
            if (k == 2'd2)      model = {8'd0, f[127:8]};
            else if (k == 2'd1) model[127:96] = f[39:8];
            else                model[31:0] = f[39:8];
        end
        expq.push_back({bad, model});
        reqq.push_back(req);
        for (int i = len - 1; i >= 0; i--) begin
            @(negedge clk);
            line = f[i];
            kind = (i == len - 1) ? k : 2'(k + 2'd1);   // R4: kind changes after start bit
        end
        stampq.push_back(ncyc);
    endtask

    // monitor: pops expectations as strobes appear
    always @(negedge clk) begin
        logic [31:0] d;
        if (!rst && !reset_checked) begin
            reset_checked = 1;
            chk("R1", "done", {127'd0, done}, 128'd0);
            chk("R1", "frame_err", {127'd0, ferr}, 128'd0);
            for (int w = 0; w < 4; w++) begin
                rd(w * 4, d);
                chk("R1", "word", {96'd0, d}, 128'd0);
            end
        end
        if (!rst && done && done_prev) begin
            checks++; fails++;
            $display("FAIL R8 done width actual=2 expected=1");
        end
        done_prev = done;
        if (!rst && (done || ferr)) begin
            if (expq.size() == 0) begin
                checks++; fails++;
                $display("FAIL R8 unexpected strobe actual=%0b%0b expected=00", done, ferr);
            end else begin
                logic [128:0] e;
                string r;
                int st;
                e  = expq.pop_front();
                r  = reqq.pop_front();
                st = stampq.pop_front();
                chk("R8", "strobe cycle", 128'(ncyc), 128'(st + 2));
                chk("R9", "frame_err", {127'd0, ferr}, {127'd0, e[128]});
                chk("R9", "done", {127'd0, done}, {127'd0, ~e[128]});
                for (int w = 0; w < 4; w++) begin
                    rd(w * 4, d);
                    chk(r, "R2 word", {96'd0, d}, {96'd0, e[w*32 +: 32]});
                end
                rd(16, d);  chk("R3", "addr 16", {96'd0, d}, 128'd0);
                rd(2, d);   chk("R3", "addr 2", {96'd0, d}, 128'd0);
                rd(63, d);  chk("R3", "addr 63", {96'd0, d}, 128'd0);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(3);
        send(2'd0, short_f(32'hA5A5_0001, 1'b1), "R5");
        idle(4);
        send(2'd1, short_f(32'hDEAD_BEEF, 1'b1), "R6");
        idle(4);
        send(2'd0, short_f(32'h1234_5678, 1'b1), "R5");
        idle(4);
        send(2'd2, long_f(120'hF0E1D2C3B4A5968778695A4B3C2D1E, 1'b1), "R7");
        idle(4);
        send(2'd3, short_f(32'h0BAD_CAFE, 1'b1), "R4");
        idle(4);
        send(2'd1, short_f(32'h7777_8888, 1'b0), "R9");
        idle(4);
        send(2'd0, short_f(32'hC001_D00D, 1'b1), "R10");
        send(2'd1, short_f(32'h5555_AAAA, 1'b1), "R10");
        idle(4);
        send(2'd2, long_f(120'h0123456789ABCDEF0123456789ABCD, 1'b0), "R9");
        idle(4);
        send(2'd1, short_f(32'hFEED_F00D, 1'b1), "R6");
        idle(4);
        send(2'd2, long_f(120'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF, 1'b1), "R7");
        idle(10);
        wait (expq.size() == 0);
        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule